// File: doc/BRIEF.md
# Prescaled Modulo Timer Time Base

This block is the shared 16-bit time base for a group of capture and compare channels. It is an up-counter whose advance enable comes from one of several sources. Seven of them are divided copies of the bus clock, in powers of two. The eighth is an external clock pin, which is synchronized and edge-detected. A 3-bit select input picks the source.

The counter wraps back to zero on the advance after it equals a programmable 16-bit limit, and it then raises a sticky overflow flag. The limit is loaded one byte at a time. Its reset value of all ones gives free-running behaviour.

A stop input holds both the prescaler and the counter at zero. The host reads the count over a byte-wide port. Reading the high byte captures the low byte, so a high-then-low read pair returns one coherent value, and no read ever disturbs the count.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, `count_o` is 0x0000, `ovf_o` is 0, `rd_data_o` is 0x00, and the limit is 0xFFFF.
- R2: While `stop_i` is high, the count is forced to zero at every clock edge and the prescaler phase is cleared.
- R3: For `sel_i` codes 0 to 6, a 6-bit prescaler phase starts at 0 after reset or stop and steps every clock. The count advances on each clock edge where the low `sel_i` bits of the phase are all ones. Code k therefore advances once every 2^k clocks, and the first advance after stop is released comes at the 2^k-th edge.
- R4: With `sel_i` = 7, the count advances once for each rising edge of `ext_clk_i`. If the pin is first sampled high at clock edge n, the count changes at edge n+2. A pin held high gives no further advances.
- R5: On an advance, the count goes up by one. If the count equals the limit, the advance instead returns it to 0x0000 and sets `ovf_o`.
- R6: With the limit at 0xFFFF, the count runs through 0xFFFF, wraps to 0x0000 and sets `ovf_o`.
- R7: `ovf_o` stays set until a clock edge with `ovf_clr_i` high. A wrap in the same cycle as a clear leaves it set.
- R8: `mod_hi_we_i` loads `wdata_i` into limit bits 15:8, and `mod_lo_we_i` loads it into bits 7:0. The new limit is used from the next clock edge.
- R9: While `rd_hi_i` is high, `rd_data_o` shows count bits 15:8 and the clock edge captures bits 7:0. A later `rd_lo_i` returns the captured byte and clears the capture. `rd_lo_i` with no pending capture shows the live bits 7:0. With neither strobe high, `rd_data_o` is 0x00. If both strobes are high, `rd_hi_i` wins.
- R10: Read strobes never change the count sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Hold prescaler and counter at zero |
| sel_i | input | 3 | Count source: 0..6 divide by 2^code, 7 external pin |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| mod_hi_we_i | input | 1 | Load limit high byte |
| mod_lo_we_i | input | 1 | Load limit low byte |
| wdata_i | input | 8 | Limit byte data |
| ovf_clr_i | input | 1 | Clear overflow flag |
| rd_hi_i | input | 1 | Read count high byte, capture low byte |
| rd_lo_i | input | 1 | Read low byte |
| rd_data_o | output | 8 | Read data |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach are the free-running wrap at 0xFFFF and a coherent read across a low-byte carry. The stimulus gets to both by running the divide-by-one source: it issues the high-byte read exactly at count 0x00FF and then keeps counting through a full 65536-cycle wrap. A set-versus-clear collision on the overflow flag is built by writing a small limit and raising the clear in the cycle the count equals it. Random phases then mix stop pulses, source changes, a fast-toggling external pin, limit writes and read strobes, and a cycle model checks the count and the flag on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_EXT = '1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler import tmr_pkg::*; #(
  parameter int unsigned PS_TAPS     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_clk_i,
  output logic             tick_o
);
  localparam int unsigned PH_W = PS_TAPS - 1;

  logic [PH_W-1:0]        ph_q;
  logic [PS_TAPS-1:0]     tap;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_edge;
  logic                   tap_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (stop_i) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end

  // tap k fires when the low k phase bits are all ones
  for (genvar k = 0; k < PS_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign tap[k] = 1'b1;
    end else begin : g_divn
      assign tap[k] = &ph_q[k-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    tap_sel = 1'b0;
    for (int k = 0; k < PS_TAPS; k++) begin
      if (int'(sel_i) == k) tap_sel = tap[k];
    end
  end

  assign tick_o = (sel_i == SEL_EXT) ? ext_edge : tap_sel;

  a_r2_stop_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (ph_q == '0));

  a_r3_div2_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && sel_i == 3'd1 && tick_o) |=> (sel_i != 3'd1 || !tick_o));

  a_r4_ext_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_EXT && tick_o) |=> (sel_i != SEL_EXT || !tick_o));
endmodule

// File: rtl/tmr_modreg.sv
module tmr_modreg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hi_we_i,
  input  logic               lo_we_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  output logic [CNT_W-1:0]   mod_o
);
  localparam int unsigned BYTE_W = CNT_W / 2;

  logic [BYTE_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '1;
      lo_q <= '1;
    end else begin
      if (hi_we_i) hi_q <= wdata_i;
      if (lo_we_i) lo_q <= wdata_i;
    end
  end

  assign mod_o = {hi_q, lo_q};

  a_r8_hi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> (mod_o[CNT_W-1:BYTE_W] == $past(wdata_i)));

  a_r8_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> (mod_o[BYTE_W-1:0] == $past(wdata_i)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_lim;
  logic             wrap;

  assign at_lim = (cnt_q == mod_i);
  assign wrap   = ~stop_i & tick_i & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (stop_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r2_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_q == '0));

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && tick_i && cnt_q != mod_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && tick_i && cnt_q == mod_i) |=> (cnt_q == '0 && ovf_q));

  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !tick_i) |=> $stable(cnt_q));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/tmr_rdlatch.sv
module tmr_rdlatch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_hi_i,
  input  logic               rd_lo_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [CNT_W/2-1:0] rd_data_o
);
  localparam int unsigned BYTE_W = CNT_W / 2;

  logic [BYTE_W-1:0] lo_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else if (rd_hi_i) begin
      lo_q   <= cnt_i[BYTE_W-1:0];
      pend_q <= 1'b1;
    end else if (rd_lo_i) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (rd_hi_i)      rd_data_o = cnt_i[CNT_W-1:BYTE_W];
    else if (rd_lo_i) rd_data_o = pend_q ? lo_q : cnt_i[BYTE_W-1:0];
    else              rd_data_o = '0;
  end

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> (pend_q && lo_q == $past(cnt_i[BYTE_W-1:0])));

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i) |=> !pend_q);
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase import tmr_pkg::*; #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PS_TAPS     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               ext_clk_i,
  input  logic               mod_hi_we_i,
  input  logic               mod_lo_we_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic               ovf_clr_i,
  input  logic               rd_hi_i,
  input  logic               rd_lo_i,
  output logic [CNT_W/2-1:0] rd_data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               ovf_o
);
  logic             tick;
  logic [CNT_W-1:0] mod_val;
  logic [CNT_W-1:0] cnt;

  tmr_prescaler #(.PS_TAPS(PS_TAPS), .SYNC_STAGES(SYNC_STAGES)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_i    (stop_i),
    .sel_i     (sel_i),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  tmr_modreg #(.CNT_W(CNT_W)) u_mod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_we_i (mod_hi_we_i),
    .lo_we_i (mod_lo_we_i),
    .wdata_i (wdata_i),
    .mod_o   (mod_val)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_i    (stop_i),
    .tick_i    (tick),
    .mod_i     (mod_val),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (cnt),
    .ovf_o     (ovf_o)
  );

  tmr_rdlatch #(.CNT_W(CNT_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_hi_i   (rd_hi_i),
    .rd_lo_i   (rd_lo_i),
    .cnt_i     (cnt),
    .rd_data_o (rd_data_o)
  );

  assign count_o = cnt;

  // R10: reads only touch the capture path
  a_r10_read_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_hi_i || rd_lo_i) && !stop_i && !tick) |=> $stable(count_o));
endmodule

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic        ext = 1'b0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic        ovf_clr = 1'b0;
  logic        rd_hi = 1'b0, rd_lo = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] count;
  logic        ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_en  = 1'b0;

  always #10 clk = ~clk;

  tmr_timebase u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .sel_i(sel), .ext_clk_i(ext),
    .mod_hi_we_i(hi_we), .mod_lo_we_i(lo_we), .wdata_i(wdata), .ovf_clr_i(ovf_clr),
    .rd_hi_i(rd_hi), .rd_lo_i(rd_lo), .rd_data_o(rd_data), .count_o(count), .ovf_o(ovf)
  );

  // cycle model built from the requirements
  logic [5:0]  m_ph  = '0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_mod = 16'hFFFF;
  logic        m_ovf = 1'b0;
  logic        m_s1 = 1'b0, m_s2 = 1'b0, m_prv = 1'b0;
  logic        m_tk, m_set;
  logic [5:0]  m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = '0; m_cnt = '0; m_mod = 16'hFFFF; m_ovf = 1'b0;
      m_s1 = 1'b0; m_s2 = 1'b0; m_prv = 1'b0;
    end else begin
      m_mask = 6'((32'd1 << sel) - 32'd1);
      if (sel == 3'd7) m_tk = m_s2 & ~m_prv;
      else             m_tk = ((m_ph & m_mask) == m_mask);
      m_set = 1'b0;
      if (stop) m_cnt = '0;
      else if (m_tk) begin
        if (m_cnt == m_mod) begin m_cnt = '0; m_set = 1'b1; end
        else m_cnt = m_cnt + 16'd1;
      end
      if (m_set) m_ovf = 1'b1;
      else if (ovf_clr) m_ovf = 1'b0;
      if (hi_we) m_mod[15:8] = wdata;
      if (lo_we) m_mod[7:0]  = wdata;
      m_ph  = stop ? 6'd0 : m_ph + 6'd1;
      m_prv = m_s2; m_s2 = m_s1; m_s1 = ext;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R5 / R7 / R10: count and flag match the model on every cycle
  always @(negedge clk) begin
    if (chk_en) begin
      chk("R5 count", 32'(count), 32'(m_cnt));
      chk("R7 ovf", 32'(ovf), 32'(m_ovf));
    end
  end

  task automatic wr_mod(input logic [15:0] v);
    @(negedge clk); hi_we = 1'b1; wdata = v[15:8];
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; wdata = v[7:0];
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R2 stop zero", 32'(count), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp_lo;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 ovf", 32'(ovf), 32'h0);
    chk("R1 rd_data", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R9 coherent read across a low-byte carry
    while (m_cnt != 16'h00FF) @(negedge clk);
    rd_hi = 1'b1; #1;
    chk("R9 hi byte", 32'(rd_data), 32'h00);
    exp_lo = 8'hFF;
    @(negedge clk); rd_hi = 1'b0; rd_lo = 1'b1; #1;
    chk("R9 captured lo", 32'(rd_data), 32'(exp_lo));
    chk("R10 count moved", 32'(count), 32'h0100);
    @(negedge clk); #1;
    chk("R9 live lo", 32'(rd_data), 32'(m_cnt[7:0]));
    rd_lo = 1'b0; #1;
    chk("R9 idle", 32'(rd_data), 32'h0);

    // R6 / R1: reset limit is all ones, free-running wrap
    while (m_cnt != 16'hFFFF) @(negedge clk);
    @(negedge clk);
    chk("R6 wrap count", 32'(count), 32'h0);
    chk("R6 wrap ovf", 32'(ovf), 32'h1);
    ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R7 clear", 32'(ovf), 32'h0);

    // R8 limit 5, R7 set beats clear
    wr_mod(16'h0005);
    stop_pulse();
    while (m_cnt != 16'd5) @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8 wrap at limit", 32'(count), 32'h0);
    chk("R7 set wins", 32'(ovf), 32'h1);

    // R3 divide by 8: first advance at 8th edge after stop
    @(negedge clk); sel = 3'd3;
    stop_pulse();
    repeat (7) begin
      @(negedge clk);
      chk("R3 div8 wait", 32'(count), 32'h0);
    end
    @(negedge clk);
    chk("R3 div8 step", 32'(count), 32'h1);

    // R4 external pin
    wr_mod(16'hFFFF);
    @(negedge clk); sel = 3'd7; ext = 1'b0;
    stop_pulse();
    repeat (4) @(negedge clk);
    ext = 1'b1;
    @(negedge clk); chk("R4 sync 1", 32'(count), 32'h0);
    @(negedge clk); chk("R4 sync 2", 32'(count), 32'h0);
    @(negedge clk); chk("R4 edge", 32'(count), 32'h1);
    repeat (5) @(negedge clk);
    chk("R4 held high", 32'(count), 32'h1);
    ext = 1'b0;
    repeat (3) @(negedge clk);
    ext = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 second edge", 32'(count), 32'h2);

    // random phase; R10 reads interleaved with model checks
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      stop    = ($urandom % 1000) < 15;
      if (($urandom % 100) < 3) sel = 3'($urandom % 8);
      ext     = 1'($urandom % 2);
      hi_we   = ($urandom % 200) == 0;
      lo_we   = ($urandom % 50) == 0;
      wdata   = hi_we ? 8'h00 : 8'($urandom % 64);
      ovf_clr = ($urandom % 20) == 0;
      rd_hi   = ($urandom % 10) == 0;
      rd_lo   = ($urandom % 10) == 1;
    end
    @(negedge clk);
    stop = 1'b0; hi_we = 1'b0; lo_we = 1'b0; ovf_clr = 1'b0; rd_hi = 1'b0; rd_lo = 1'b0;
    @(negedge clk);
    chk_en = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule